// File: doc/BRIEF.md
# Windowed Cross-Correlation Delay Finder

This block estimates the relative delay between two channels of a captured signal. It reads offset-free records for a left and a right channel out of an external capture memory. The correlation does not span the whole record. Instead, it uses a window of samples that is centred on a peak index, which the caller supplies. For every candidate shift in a symmetric range around zero, the block sums sample products over that window. It reports the shift that gives the largest sum, as a signed delay in samples, together with that sum.

A single multiply-accumulate datapath is shared by all shifts. A small sequencer steps through the shifts, and for each shift it walks the window index. It issues one read pair per cycle, and the memory answers one cycle later. For a positive shift the block moves the right channel forward in time against the left. For a negative shift it moves the left channel forward against the right. This lets one loop cover both directions without a full-length correlation. Converting the delay into a distance or an angle is done downstream.

Top module: `corr_lag_search`

## Requirements
- R1: For every shift, the sum covers exactly the indices n from peak-HALF_WIN to peak+HALF_WIN inclusive (2*HALF_WIN+1 terms). A sample outside that span never contributes.
- R2: Shifts run from -MAX_LAG to +MAX_LAG and include zero. Shift k>=0 sums left[n]*right[n+k]. Shift k<0 sums left[n-k]*right[n].
- R3: A term whose left or right index falls outside 0..REC_LEN-1 contributes zero. No read strobe is raised for that term.
- R4: Samples are signed Q1.15. Each product is kept exactly at 32 bits, and the accumulator (2*DW+clog2(2*HALF_WIN+1)+1 bits) holds the full sum without overflow, even for full-scale inputs.
- R5: The reported shift has the largest sum. On equal sums, the smaller absolute shift wins. If the absolute shifts are also equal, the negative shift wins.
- R6: done_o is a one-cycle pulse. It rises exactly (2*MAX_LAG+1)*(2*HALF_WIN+1)+2 clock edges after the edge that accepts start_i.
- R7: best_lag_o and best_val_o are zero after reset. They change only in the cycle done_o is high, and otherwise hold their value.
- R8: A start_i pulse that arrives while a search is in progress is ignored. The running search keeps its peak index and its timing.
- R9: A read is a strobe rd_en_o with the addresses rd_addr_l_o and rd_addr_r_o. The memory must present the data on rd_dat_l_i and rd_dat_r_i in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a search (accepted when idle) |
| peak_i | input | AW | Window centre index, sampled at start |
| rd_en_o | output | 1 | Read strobe for both channels |
| rd_addr_l_o | output | AW | Left-channel read address |
| rd_addr_r_o | output | AW | Right-channel read address |
| rd_dat_l_i | input | DW | Left sample, one cycle after strobe |
| rd_dat_r_i | input | DW | Right sample, one cycle after strobe |
| done_o | output | 1 | One-cycle result pulse |
| best_lag_o | output | LW | Signed winning shift |
| best_val_o | output | ACC_W | Signed correlation sum at the winning shift |

## Verification
The hardest situations to reach are the ones where the window or a shifted index runs past either end of the record, and exact ties between shifts. The bench places the peak index at 1 and at REC_LEN-2, so that only some terms are out of range. It also builds a pattern with one impulse on the left channel and two impulses on the right channel, one on each side of it. That pattern gives equal sums at -1 and +1, with zero at the aligned position. A full-scale constant record makes every shift tie at the largest possible value, which tests both the tie rule and the accumulator width at the same time.

// File: rtl/corr_pkg.sv
package corr_pkg;

  // Evaluation order of shifts: 0, -1, +1, -2, +2, ...
  function automatic int lag_of(input int idx);
    if (idx == 0) return 0;
    else if ((idx % 2) == 1) return -((idx + 1) / 2);
    else return idx / 2;
  endfunction

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

endpackage

// File: rtl/corr_seq.sv
module corr_seq #(
  parameter int REC_LEN  = 1024,
  parameter int HALF_WIN = 500,
  parameter int MAX_LAG  = 20,
  parameter int AW       = $clog2(REC_LEN),
  parameter int LW       = $clog2(MAX_LAG + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 idle_i,
  input  logic [AW-1:0]        peak_i,
  output logic                 accept_o,
  output logic                 issue_o,
  output logic                 rd_en_o,
  output logic [AW-1:0]        addr_l_o,
  output logic [AW-1:0]        addr_r_o,
  output logic                 term_in_o,
  output logic                 term_last_o,
  output logic                 term_final_o,
  output logic signed [LW-1:0] term_lag_o
);
  import corr_pkg::*;

  localparam int NTERM = 2 * HALF_WIN + 1;
  localparam int NLAG  = 2 * MAX_LAG + 1;
  localparam int JW    = $clog2(NTERM);
  localparam int XW    = (NLAG > 1) ? $clog2(NLAG) : 1;

  logic          busy_q;
  logic [JW-1:0] j_q;
  logic [XW-1:0] idx_q;
  logic [AW-1:0] peak_q;
  logic          last_j, last_lag;
  int            cur_lag, n_base, n_l, n_r;
  logic          in_rng;

  assign accept_o = start_i && !busy_q && idle_i;
  assign last_j   = (j_q == JW'(NTERM - 1));
  assign last_lag = (idx_q == XW'(NLAG - 1));

  always_comb begin
    cur_lag = lag_of(int'(idx_q));
    n_base  = int'(peak_q) - HALF_WIN + int'(j_q);
    n_l     = n_base + ((cur_lag < 0) ? -cur_lag : 0);
    n_r     = n_base + ((cur_lag > 0) ? cur_lag : 0);
    in_rng  = (n_l >= 0) && (n_l < REC_LEN) && (n_r >= 0) && (n_r < REC_LEN);
  end

  assign issue_o      = busy_q;
  assign rd_en_o      = busy_q && in_rng;
  assign addr_l_o     = AW'(n_l);
  assign addr_r_o     = AW'(n_r);
  assign term_in_o    = in_rng;
  assign term_last_o  = last_j;
  assign term_final_o = last_j && last_lag;
  assign term_lag_o   = LW'(cur_lag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      j_q    <= '0;
      idx_q  <= '0;
      peak_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      j_q    <= '0;
      idx_q  <= '0;
      peak_q <= peak_i;
    end else if (busy_q) begin
      if (last_j) begin
        j_q <= '0;
        if (last_lag) busy_q <= 1'b0;
        else          idx_q  <= idx_q + 1'b1;
      end else begin
        j_q <= j_q + 1'b1;
      end
    end
  end

  a_r2_lag_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cur_lag <= MAX_LAG && cur_lag >= -MAX_LAG));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !(last_j && last_lag)) |=> (busy_q && peak_q == $past(peak_q)));

endmodule

// File: rtl/corr_mac.sv
module corr_mac #(
  parameter int DW    = 16,
  parameter int ACC_W = 43,
  parameter int LW    = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue_i,
  input  logic                    term_in_i,
  input  logic                    term_last_i,
  input  logic                    term_final_i,
  input  logic signed [LW-1:0]    term_lag_i,
  input  logic signed [DW-1:0]    dat_l_i,
  input  logic signed [DW-1:0]    dat_r_i,
  output logic                    busy_o,
  output logic                    sum_vld_o,
  output logic                    sum_final_o,
  output logic signed [LW-1:0]    sum_lag_o,
  output logic signed [ACC_W-1:0] sum_o
);
  localparam int PW = 2 * DW;

  function automatic logic signed [PW-1:0] q_mul(input logic signed [DW-1:0] a,
                                                 input logic signed [DW-1:0] b);
    logic signed [PW-1:0] ae, be;
    ae = PW'(a);
    be = PW'(b);
    return ae * be;
  endfunction

  logic                    p1_vld, p1_in, p1_last, p1_final;
  logic signed [LW-1:0]    p1_lag;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [PW-1:0]    prod;
  logic signed [ACC_W:0]   acc_ext;

  always_comb begin
    prod    = p1_in ? q_mul(dat_l_i, dat_r_i) : '0;
    acc_ext = {acc_q[ACC_W-1], acc_q} + {{(ACC_W + 1 - PW){prod[PW-1]}}, prod};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1_vld      <= 1'b0;
      p1_in       <= 1'b0;
      p1_last     <= 1'b0;
      p1_final    <= 1'b0;
      p1_lag      <= '0;
      acc_q       <= '0;
      sum_vld_o   <= 1'b0;
      sum_final_o <= 1'b0;
      sum_lag_o   <= '0;
      sum_o       <= '0;
    end else begin
      p1_vld    <= issue_i;
      p1_in     <= term_in_i;
      p1_last   <= issue_i && term_last_i;
      p1_final  <= issue_i && term_final_i;
      p1_lag    <= term_lag_i;
      sum_vld_o <= 1'b0;
      if (p1_vld) begin
        if (p1_last) begin
          sum_o       <= acc_ext[ACC_W-1:0];
          sum_vld_o   <= 1'b1;
          sum_final_o <= p1_final;
          sum_lag_o   <= p1_lag;
          acc_q       <= '0;
        end else begin
          acc_q <= acc_ext[ACC_W-1:0];
        end
      end
    end
  end

  assign busy_o = p1_vld || sum_vld_o;

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    p1_vld |-> (acc_ext[ACC_W] == acc_ext[ACC_W-1]));

  a_r3_masked_term: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_vld && !p1_in) |-> (prod == '0));

endmodule

// File: rtl/corr_best.sv
module corr_best #(
  parameter int ACC_W = 43,
  parameter int LW    = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_i,
  input  logic                    sum_vld_i,
  input  logic                    sum_final_i,
  input  logic signed [LW-1:0]    sum_lag_i,
  input  logic signed [ACC_W-1:0] sum_i,
  output logic                    done_o,
  output logic signed [LW-1:0]    best_lag_o,
  output logic signed [ACC_W-1:0] best_val_o
);
  import corr_pkg::*;

  function automatic logic beats(input logic signed [ACC_W-1:0] cv,
                                 input int cl,
                                 input logic signed [ACC_W-1:0] bv,
                                 input int bl);
    if (cv != bv) return cv > bv;
    if (abs_i(cl) != abs_i(bl)) return abs_i(cl) < abs_i(bl);
    return cl < bl;
  endfunction

  logic                    have_q, take;
  logic signed [ACC_W-1:0] run_val, nxt_val;
  logic signed [LW-1:0]    run_lag, nxt_lag;

  always_comb begin
    take    = !have_q || beats(sum_i, int'(sum_lag_i), run_val, int'(run_lag));
    nxt_val = take ? sum_i : run_val;
    nxt_lag = take ? sum_lag_i : run_lag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q     <= 1'b0;
      run_val    <= '0;
      run_lag    <= '0;
      done_o     <= 1'b0;
      best_lag_o <= '0;
      best_val_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (clear_i) begin
        have_q <= 1'b0;
      end else if (sum_vld_i) begin
        have_q  <= 1'b1;
        run_val <= nxt_val;
        run_lag <= nxt_lag;
        if (sum_final_i) begin
          best_val_o <= nxt_val;
          best_lag_o <= nxt_lag;
          done_o     <= 1'b1;
        end
      end
    end
  end

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r5_best_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_vld_i && have_q && !clear_i) |=> (run_val >= $past(run_val)));

endmodule

// File: rtl/corr_lag_search.sv
module corr_lag_search #(
  parameter int DW       = 16,
  parameter int REC_LEN  = 1024,
  parameter int HALF_WIN = 500,
  parameter int MAX_LAG  = 20,
  parameter int AW       = $clog2(REC_LEN),
  parameter int LW       = $clog2(MAX_LAG + 1) + 1,
  parameter int ACC_W    = 2 * DW + $clog2(2 * HALF_WIN + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [AW-1:0]           peak_i,
  output logic                    rd_en_o,
  output logic [AW-1:0]           rd_addr_l_o,
  output logic [AW-1:0]           rd_addr_r_o,
  input  logic signed [DW-1:0]    rd_dat_l_i,
  input  logic signed [DW-1:0]    rd_dat_r_i,
  output logic                    done_o,
  output logic signed [LW-1:0]    best_lag_o,
  output logic signed [ACC_W-1:0] best_val_o
);
  logic                    accept, issue, t_in, t_last, t_final, mac_busy;
  logic signed [LW-1:0]    t_lag, s_lag;
  logic                    s_vld, s_final;
  logic signed [ACC_W-1:0] s_val;

  corr_seq #(.REC_LEN(REC_LEN), .HALF_WIN(HALF_WIN), .MAX_LAG(MAX_LAG),
             .AW(AW), .LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .idle_i(!mac_busy),
    .peak_i(peak_i), .accept_o(accept), .issue_o(issue), .rd_en_o(rd_en_o),
    .addr_l_o(rd_addr_l_o), .addr_r_o(rd_addr_r_o), .term_in_o(t_in),
    .term_last_o(t_last), .term_final_o(t_final), .term_lag_o(t_lag));

  corr_mac #(.DW(DW), .ACC_W(ACC_W), .LW(LW)) u_mac (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .term_in_i(t_in),
    .term_last_i(t_last), .term_final_i(t_final), .term_lag_i(t_lag),
    .dat_l_i(rd_dat_l_i), .dat_r_i(rd_dat_r_i), .busy_o(mac_busy),
    .sum_vld_o(s_vld), .sum_final_o(s_final), .sum_lag_o(s_lag), .sum_o(s_val));

  corr_best #(.ACC_W(ACC_W), .LW(LW)) u_best (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .sum_vld_i(s_vld),
    .sum_final_i(s_final), .sum_lag_i(s_lag), .sum_i(s_val),
    .done_o(done_o), .best_lag_o(best_lag_o), .best_val_o(best_val_o));

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(best_lag_o) && $stable(best_val_o)));

  a_r9_read_in_record: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> (int'(rd_addr_l_o) < REC_LEN && int'(rd_addr_r_o) < REC_LEN));

endmodule

// File: tb/test_corr_lag_search.sv
module test_corr_lag_search;
  localparam int DW   = 16;
  localparam int REC  = 40;
  localparam int W    = 6;
  localparam int L    = 3;
  localparam int AW   = $clog2(REC);
  localparam int LW   = $clog2(L + 1) + 1;
  localparam int ACCW = 2 * DW + $clog2(2 * W + 1) + 1;
  localparam int LAT  = (2 * L + 1) * (2 * W + 1) + 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] peak = '0;
  logic rd_en, done;
  logic [AW-1:0] a_l, a_r;
  logic signed [DW-1:0] d_l = '0, d_r = '0;
  logic signed [LW-1:0] b_lag;
  logic signed [ACCW-1:0] b_val;
  logic signed [DW-1:0] mem_l [REC];
  logic signed [DW-1:0] mem_r [REC];
  int checks = 0, fails = 0;
  logic bad_rd = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;

  corr_lag_search #(.DW(DW), .REC_LEN(REC), .HALF_WIN(W), .MAX_LAG(L)) i_corr_lag_search (
    .clk(clk), .rst_n(rst_n), .start_i(start), .peak_i(peak), .rd_en_o(rd_en),
    .rd_addr_l_o(a_l), .rd_addr_r_o(a_r), .rd_dat_l_i(d_l), .rd_dat_r_i(d_r),
    .done_o(done), .best_lag_o(b_lag), .best_val_o(b_val));

  // R9: data returned one cycle after the strobe
  always @(posedge clk) begin
    if (rd_en) begin
      if (int'(a_l) >= REC || int'(a_r) >= REC) bad_rd <= 1'b1;
      else begin
        d_l <= mem_l[a_l];
        d_r <= mem_r[a_r];
      end
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wave(input int i);
    return (((i * 37 + 11) * (i + 3)) % 61 - 30) * 700;
  endfunction

  // independent reference: scan shifts from -L to +L
  task automatic ref_model(input int pk, output longint lag, output longint val);
    bit have = 0;
    lag = 0; val = 0;
    for (int k = -L; k <= L; k++) begin
      longint s = 0;
      for (int n = pk - W; n <= pk + W; n++) begin
        int il = (k < 0) ? n - k : n;
        int ir = (k > 0) ? n + k : n;
        if (il >= 0 && il < REC && ir >= 0 && ir < REC)
          s += longint'(mem_l[il]) * longint'(mem_r[ir]);
      end
      if (!have || s > val ||
          (s == val && ((k < 0 ? -k : k) < (lag < 0 ? -lag : lag) ||
                        ((k < 0 ? -k : k) == (lag < 0 ? -lag : lag) && k < lag)))) begin
        have = 1; val = s; lag = k;
      end
    end
  endtask

  task automatic run_search(input int pk, output longint lag, output longint val, output int cyc);
    @(negedge clk); start = 1'b1; peak = AW'(pk);
    @(posedge clk); #1 start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk); #1 cyc++;
    end
    lag = b_lag; val = b_val;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < REC; i++) begin mem_l[i] = '0; mem_r[i] = '0; end
  endtask

  task automatic fill_delay(input int d);
    for (int i = 0; i < REC; i++) begin
      mem_l[i] = DW'(wave(i));
      mem_r[i] = (i - d >= 0 && i - d < REC) ? DW'(wave(i - d)) : DW'(wave(i + 50));
    end
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(b_lag == 0 && b_val == 0, "R7 reset outputs", b_val, 0);
    chk(rd_en == 1'b0, "R9 no read at reset", rd_en, 0);
  endtask

  task automatic t_delay(input int d, input int pk, input string tag);
    longint gl, gv, el, ev; int cyc;
    fill_delay(d);
    ref_model(pk, el, ev);
    run_search(pk, gl, gv, cyc);
    chk(gl == el, {tag, " lag vs model"}, gl, el);
    chk(gv == ev, {tag, " value vs model"}, gv, ev);
    chk(gl == d, {tag, " lag equals applied delay"}, gl, d);
    chk(cyc == LAT, "R6 latency", cyc, LAT);
  endtask

  task automatic t_edge(input int pk, input string tag);
    longint gl, gv, el, ev; int cyc;
    fill_delay(1);
    ref_model(pk, el, ev);
    run_search(pk, gl, gv, cyc);
    chk(gl == el, {tag, " lag"}, gl, el);
    chk(gv == ev, {tag, " value"}, gv, ev);
    chk(!bad_rd, "R3 no out-of-record strobe", bad_rd, 0);
  endtask

  task automatic t_window();
    longint gl, gv; int cyc;
    clear_mem();
    mem_l[20] = 16'sd100; mem_r[20] = 16'sd100;
    mem_l[20 + W + 1] = 16'sd30000; mem_r[20 + W + 1] = 16'sd30000;
    run_search(20, gl, gv, cyc);
    chk(gl == 0, "R1 window lag", gl, 0);
    chk(gv == 10000, "R1 sample past window excluded", gv, 10000);
  endtask

  task automatic t_tie();
    longint gl, gv; int cyc;
    clear_mem();
    mem_l[20] = 16'sd1000; mem_r[21] = 16'sd1000; mem_r[19] = 16'sd1000;
    run_search(20, gl, gv, cyc);
    chk(gl == -1, "R5 tie +1/-1 picks negative", gl, -1);
    chk(gv == 1000000, "R5 tie value", gv, 1000000);
    clear_mem();
    run_search(20, gl, gv, cyc);
    chk(gl == 0, "R5 all-zero tie picks zero", gl, 0);
    chk(gv == 0, "R5 all-zero value", gv, 0);
  endtask

  task automatic t_full_scale();
    longint gl, gv, ev; int cyc;
    for (int i = 0; i < REC; i++) begin mem_l[i] = 16'sh8000; mem_r[i] = 16'sh8000; end
    ev = longint'(2 * W + 1) * (longint'(1) << 30);
    run_search(20, gl, gv, cyc);
    chk(gv == ev, "R4 full-scale sum exact", gv, ev);
    chk(gl == 0, "R5 full-scale tie picks zero", gl, 0);
  endtask

  task automatic t_start_busy();
    longint el, ev; int cyc;
    fill_delay(-2);
    ref_model(18, el, ev);
    @(negedge clk); start = 1'b1; peak = AW'(18);
    @(posedge clk); #1 start = 1'b0;
    cyc = 0;
    repeat (10) begin @(posedge clk); #1 cyc++; end
    @(negedge clk); start = 1'b1; peak = AW'(5);
    @(posedge clk); #1 start = 1'b0; cyc++;
    while (!done && cyc < 5000) begin @(posedge clk); #1 cyc++; end
    chk(b_lag == el, "R8 second start ignored lag", b_lag, el);
    chk(b_val == ev, "R8 second start ignored value", b_val, ev);
    chk(cyc == LAT, "R8 timing unchanged", cyc, LAT);
    chk(b_lag == -2, "R2 left-shift direction", b_lag, -2);
  endtask

  task automatic t_hold();
    logic signed [LW-1:0] hl; logic signed [ACCW-1:0] hv; int pulses = 0;
    @(posedge clk); #1;
    chk(done == 1'b0, "R6 done single cycle", done, 0);
    hl = b_lag; hv = b_val;
    clear_mem();
    repeat (20) begin @(posedge clk); #1 if (done) pulses++; end
    chk(b_lag == hl && b_val == hv, "R7 outputs held", b_val, hv);
    chk(pulses == 0, "R7 no spurious done", pulses, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    clear_mem();
    t_reset();
    t_delay(2, 20, "R2 right delayed");
    t_delay(-3, 20, "R2 left delayed");
    t_delay(0, 15, "R2 aligned");
    t_edge(1, "R3 peak near start");
    t_edge(REC - 2, "R3 peak near end");
    t_window();
    t_tie();
    t_full_scale();
    t_start_busy();
    t_hold();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule